// File: doc/BRIEF.md
# Glitch-Free Reconfigurable PWM Generator

This block produces one pulse-width modulated output from a slow time-base tick. The tick has a fixed rate of 1 MHz and arrives as a single-cycle enable in the fast system clock domain. A 2-bit divider selects how many ticks make up one counter step. The period count sets how many steps make up one cycle. The duty count sets how many steps at the start of each cycle drive the output high.

Software programs the block through a small write port. Each write goes into a staging copy. The running waveform keeps using its live copy until two things have happened: the period field has been written, and the cycle in progress has reached its last step. At that edge the divider, duty and period all move into the live copy together. A period of zero is the off state. Switching off waits for the cycle in progress to finish and then holds the output low. When the block is already off, a staged configuration goes live on the next clock.

Top module: `pwm_shadow`

## Requirements
- R1: After reset, and after any later reset, the output is low. The live and staged settings are zero and no transfer is pending, so the output stays low until the block is configured.
- R2: The divider field is written at address 0, bits [1:0]. The codes 0, 1, 2 and 3 make one counter step last 1, 2, 4 and 8 ticks.
- R3: With live duty D and live period P (0 < D < P), each cycle lasts P steps. The output is high for the first D steps and low for the rest.
- R4: Writes to address 0 (divider) and address 1 (duty) change only the staged copy. Without a period write, the running waveform never changes.
- R5: A write to address 2 (period) arms a transfer. At the end of the cycle in progress, all staged fields become live at the same clock edge, so no cycle mixes old and new values.
- R6: Staging a period of zero lets the cycle in progress finish with its full high time. From then on the output stays low.
- R7: While the live period is zero, an armed transfer is taken on the next clock and a new cycle starts at once.
- R8: A live duty of zero keeps the output low for every cycle.
- R9: A live duty equal to or greater than the live period keeps the output high for every cycle.
- R10: A second period write before the armed transfer is taken replaces the staged values. Only one transfer happens, and it uses the latest values.
- R11: A period write in the same clock as a cycle-end transfer does not join that transfer. The transfer uses the values staged before the write. The new write stays armed and takes effect at the following cycle end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1us | input | 1 | One-clock enable marking each 1 MHz time-base tick |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_addr | input | 2 | Field select: 0 divider, 1 duty, 2 period |
| wr_data | input | CNT_W | Write value, low bits used for the divider |
| pwm_out | output | 1 | Modulated output |

## Verification
The two functions that can share a clock edge are a period write arming a transfer and the cycle-end transfer of the previous arming. The bench measures the current cycle length from an observed rising edge and counts clocks to time a period write onto that exact edge. It judges the outcome from the lengths of the next two cycles. The first must carry the values staged before the write, and the second the values from the write itself. A second situation, a write landing mid-cycle while a transfer is already armed, is judged the same way against a single switch to the newest values.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PRESCALE = 2'd0,
    REG_DUTY     = 2'd1,
    REG_PERIOD   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [PRE_W-1:0] sel,
  input  logic             restart,
  output logic             step
);
  localparam int CW = (1 << PRE_W) - 1;

  logic [CW-1:0] cnt_q, cnt_d, term;

  always_comb begin
    term = CW'((32'd1 << sel) - 32'd1);
    step = tick && (cnt_q == term);
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = step ? '0 : cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PRE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              commit,
  output logic [PRE_W-1:0]  act_pre,
  output logic [CNT_W-1:0]  act_duty,
  output logic [CNT_W-1:0]  act_per,
  output logic              pending
);
  logic [PRE_W-1:0] shd_pre_q, shd_pre_d, act_pre_d;
  logic [CNT_W-1:0] shd_duty_q, shd_duty_d, act_duty_d;
  logic [CNT_W-1:0] shd_per_q, shd_per_d, act_per_d;
  logic             pend_d, per_wr;

  always_comb begin
    shd_pre_d  = shd_pre_q;
    shd_duty_d = shd_duty_q;
    shd_per_d  = shd_per_q;
    per_wr     = 1'b0;
    if (wr_en) begin
      case (wr_addr)
        REG_PRESCALE: shd_pre_d  = wr_data[PRE_W-1:0];
        REG_DUTY:     shd_duty_d = wr_data;
        REG_PERIOD: begin
          shd_per_d = wr_data;
          per_wr    = 1'b1;
        end
        default: ;
      endcase
    end
    // transfer takes the staged values held before this cycle's write
    act_pre_d  = commit ? shd_pre_q  : act_pre;
    act_duty_d = commit ? shd_duty_q : act_duty;
    act_per_d  = commit ? shd_per_q  : act_per;
    pend_d     = per_wr || (pending && !commit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_pre_q  <= '0;
      shd_duty_q <= '0;
      shd_per_q  <= '0;
      act_pre    <= '0;
      act_duty   <= '0;
      act_per    <= '0;
      pending    <= 1'b0;
    end else begin
      shd_pre_q  <= shd_pre_d;
      shd_duty_q <= shd_duty_d;
      shd_per_q  <= shd_per_d;
      act_pre    <= act_pre_d;
      act_duty   <= act_duty_d;
      act_per    <= act_per_d;
      pending    <= pend_d;
    end
  end
endmodule

// File: rtl/pwm_period_core.sv
module pwm_period_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             pending,
  input  logic [CNT_W-1:0] act_duty,
  input  logic [CNT_W-1:0] act_per,
  output logic             commit,
  output logic             pwm_out
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             running, last, boundary, out_d;

  always_comb begin
    running  = (act_per != '0);
    last     = (cnt_q == act_per - CNT_W'(1));
    boundary = running && step && last;
    commit   = pending && (boundary || !running);
    cnt_d    = cnt_q;
    if (commit || !running) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = last ? '0 : cnt_q + CNT_W'(1);
    end
    out_d = running && (cnt_q < act_duty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pwm_out <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pwm_out <= out_d;
    end
  end
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PRE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1us,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              pwm_out
);
  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_int_n;
  logic [PRE_W-1:0]      act_pre;
  logic [CNT_W-1:0]      act_duty, act_per;
  logic                  pending, commit, step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[RST_STAGES-1];

  pwm_shadow_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .commit   (commit),
    .act_pre  (act_pre),
    .act_duty (act_duty),
    .act_per  (act_per),
    .pending  (pending)
  );

  pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (tick_1us),
    .sel     (act_pre),
    .restart (commit),
    .step    (step)
  );

  pwm_period_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .step     (step),
    .pending  (pending),
    .act_duty (act_duty),
    .act_per  (act_per),
    .commit   (commit),
    .pwm_out  (pwm_out)
  );
endmodule

// File: rtl/pwm_shadow_chk.sv
module pwm_shadow_chk
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              pwm_out,
  input logic [CNT_W-1:0]  act_duty,
  input logic [CNT_W-1:0]  act_per,
  input logic              pending,
  input logic              commit
);
  assert_live_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(act_per) && $stable(act_duty)));

  assert_off_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_per == '0) |=> !pwm_out);

  assert_zero_duty_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_duty == '0) |=> !pwm_out);

  assert_full_duty_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_per != '0) && (act_duty >= act_per)) |=> pwm_out);

  assert_write_arms_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == REG_PERIOD)) |=> pending);

  assert_commit_disarms_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !(wr_en && (wr_addr == REG_PERIOD))) |=> !pending);
endmodule

bind pwm_shadow pwm_shadow_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .pwm_out  (pwm_out),
  .act_duty (act_duty),
  .act_per  (act_per),
  .pending  (pending),
  .commit   (commit)
);

// File: tb/pwm_shadow_test.sv
`timescale 1ns/1ps
module pwm_shadow_test;
  localparam int CNT_W = 8;
  localparam int TPC   = 4; // clocks per time-base tick in this bench

  // table: divider code, duty, period, expected high clocks, expected period clocks
  localparam int NV = 5;
  localparam int VPRE [NV] = '{0, 1, 2, 3, 0};
  localparam int VDUTY[NV] = '{3, 2, 1, 4, 1};
  localparam int VPER [NV] = '{8, 5, 3, 6, 2};
  localparam int VHI  [NV] = '{12, 16, 16, 128, 4};
  localparam int VPC  [NV] = '{32, 40, 48, 192, 8};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick_1us = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             pwm_out;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;
  int  tph = 0;

  pwm_shadow #(.CNT_W(CNT_W), .PRE_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tph = (tph + 1) % TPC;
    tick_1us = (tph == 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    wr_en = 1'b1;
    wr_addr = 2'(addr);
    wr_data = CNT_W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input bit wait_rise, output int hi, output int per);
    int guard;
    logic prev;
    hi = 0; per = 0; guard = 0;
    if (wait_rise) begin
      prev = pwm_out;
      @(negedge clk);
      while (!(!prev && pwm_out)) begin
        prev = pwm_out;
        @(negedge clk);
        guard++;
        if (guard > 5000) begin hi = -1; per = -1; return; end
      end
    end
    while (pwm_out) begin
      hi++; per++; guard++;
      @(negedge clk);
      if (guard > 5000) begin hi = -1; per = -1; return; end
    end
    while (!pwm_out) begin
      per++; guard++;
      @(negedge clk);
      if (guard > 5000) begin hi = -1; per = -1; return; end
    end
  endtask

  task automatic count_high(input int n, output int highs);
    highs = 0;
    for (int k = 0; k < n; k++) begin
      if (pwm_out) highs++;
      @(negedge clk);
    end
  endtask

  initial begin
    int h1, p1, h2, p2, h3, p3, highs, waitc;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, output idle without configuration
    chk("R1 out after reset", int'(pwm_out), 0);
    count_high(100, highs);
    chk("R1 idle highs", highs, 0);

    // R2 / R3: table of configurations
    for (int i = 0; i < NV; i++) begin
      wr(0, VPRE[i]);
      wr(1, VDUTY[i]);
      wr(2, VPER[i]);
      measure(1'b1, h1, p1);
      chk($sformatf("R3 high clocks vec%0d", i), h1, VHI[i]);
      chk($sformatf("R2 period clocks vec%0d", i), p1, VPC[i]);
    end

    // R4: duty write alone does not change the waveform
    wr(1, 3); wr(2, 8);
    measure(1'b1, h1, p1);
    wr(1, 6);
    repeat (100) @(negedge clk);
    measure(1'b1, h1, p1);
    chk("R4 high after staged duty", h1, 12);
    chk("R4 period after staged duty", p1, 32);
    wr(2, 8);
    measure(1'b1, h1, p1);
    chk("R5 high after period write", h1, 24);

    // R5: mid-cycle write, current cycle untouched, next cycle fully new
    measure(1'b1, h1, p1);
    fork
      begin measure(1'b0, h1, p1); measure(1'b0, h2, p2); end
      begin wr(1, 2); wr(2, 10); end
    join
    chk("R5 running cycle high", h1, 24);
    chk("R5 running cycle period", p1, 32);
    chk("R5 new cycle high", h2, 8);
    chk("R5 new cycle period", p2, 40);

    // R11: period write on the exact cycle-end edge while a transfer is armed
    fork
      begin measure(1'b0, h1, p1); measure(1'b0, h2, p2); measure(1'b0, h3, p3); end
      begin wr(1, 3); wr(2, 8); repeat (36) @(negedge clk); wr(2, 10); end
    join
    chk("R11 old cycle high", h1, 8);
    chk("R11 old cycle period", p1, 40);
    chk("R11 first transfer high", h2, 12);
    chk("R11 first transfer period", p2, 32);
    chk("R11 second transfer high", h3, 12);
    chk("R11 second transfer period", p3, 40);

    // R10: two period writes before one transfer
    wr(0, 1); wr(1, 1); wr(2, 12);
    measure(1'b1, h1, p1);
    fork
      begin measure(1'b0, h1, p1); measure(1'b0, h2, p2); end
      begin wr(1, 4); wr(2, 10); repeat (5) @(negedge clk); wr(1, 2); wr(2, 6); end
    join
    chk("R10 old cycle period", p1, 96);
    chk("R10 latest high", h2, 16);
    chk("R10 latest period", p2, 48);

    // R6: disable lets the running cycle finish, then output stays low
    fork
      begin
        h1 = 0;
        while (pwm_out && h1 < 5000) begin h1++; @(negedge clk); end
      end
      begin wr(2, 0); end
    join
    chk("R6 final pulse high", h1, 16);
    count_high(300, highs);
    chk("R6 low after disable", highs, 0);

    // R7: from the off state a staged configuration starts at once
    wr(0, 0); wr(1, 2);
    wr(2, 4);
    waitc = 0;
    while (!pwm_out && waitc < 20) begin waitc++; @(negedge clk); end
    chk("R7 start delay within 3 clocks", int'(waitc <= 3), 1);
    measure(1'b1, h1, p1);
    chk("R7 high", h1, 8);
    chk("R7 period", p1, 16);

    // R8: zero duty
    wr(1, 0); wr(2, 5);
    repeat (40) @(negedge clk);
    count_high(100, highs);
    chk("R8 zero duty highs", highs, 0);

    // R9: duty above period
    wr(1, 9); wr(2, 4);
    repeat (40) @(negedge clk);
    count_high(100, highs);
    chk("R9 full duty highs", highs, 100);

    // R1: reset in the middle of operation
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 out during reset", int'(pwm_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    count_high(60, highs);
    chk("R1 low after second reset", highs, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule